// File: doc/BRIEF.md
# Packed Per-CPU Interrupt Controller

This block is a first-level interrupt controller for a system with two processors. It takes a wide vector of level-sensitive peripheral interrupt lines, synchronises them to the local clock, and drives one interrupt output per CPU. Each CPU owns a bank of registers. The bank holds one read/write enable word for every group of 32 sources, followed by one read-only status word for every group. A source interrupts a CPU only while its synchronised line is high and that CPU's enable bit for it is set. Software chooses which CPU handles a source by setting the source's enable bit in that CPU's bank only.

Enable words hold plain values. There is no separate set or clear register, so software changes one bit by reading the word, modifying it and writing it back. Inside each half of a bank the words are in reverse order: the highest-numbered group has the lowest address, and sources 0 to 31 sit in the last word. The bank for CPU1 follows directly after the bank for CPU0. Addresses beyond both banks read as zero, and writes to them are dropped.

Top module: `dual_cpu_irq_ctrl`

## Requirements
- R1: After reset every enable word reads 0, both CPU interrupt outputs are low, and the read data bus is 0.
- R2: A bank is 8*NUM_GROUPS bytes long and CPU c's bank starts at byte c*8*NUM_GROUPS. The enable word for group g (sources 32g to 32g+31, bit i = source 32g+i) is at bank offset 4*(NUM_GROUPS-1-g). It reads back the last value written to it. Read data appears on the clock edge after the read request and is 0 in every cycle with no read.
- R3: The status word for group g is at bank offset 4*NUM_GROUPS + 4*(NUM_GROUPS-1-g). With four groups, offset 0x10 covers sources 96..127 and offset 0x1C covers sources 0..31. Each bit shows the level of its input line after two synchronising flip-flops.
- R4: A write to a status address changes no status bit and no enable word.
- R5: A CPU interrupt output becomes 1 on the clock edge after some source is both set in status and enabled in that CPU's bank, for example one edge after the enabling write.
- R6: An input line that rises between clock edges raises an enabled CPU output on the third rising edge that sees it (two edges to synchronise, one for the output register).
- R7: Both banks show the same status for every source. An output is raised only for a CPU whose own enable bit for a pending source is set.
- R8: A read from an address at or above 2*8*NUM_GROUPS returns 0, and a write to such an address has no effect.
- R9: An enable write replaces all 32 bits of the word, so bits that were set before and are 0 in the new value become cleared.
- R10: A CPU output falls one edge after its last pending-and-enabled source is masked. When the input line falls instead, the output falls on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqIn | input | 32*NUM_GROUPS | Level interrupt lines, bit n = source n |
| regSel | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| irqCpu | output | NUM_CPUS | Interrupt request, one bit per CPU |

## Verification
The hardest case to reach from the ports is a CPU output that falls while the same source stays pending for the other CPU. This needs one source enabled in both banks, or two sources in different groups, and then a mask in one bank. The bench raises source 127 with it enabled only in CPU1's bank while source 0 stays live for CPU0. It then clears CPU0's whole enable word and checks that only CPU0's output drops. It also counts edges after each input change, so that the two-flop synchroniser delay and the output register delay can each be checked on their own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_BITS = 32;
  localparam int IDX_W = 4;

  // Strobes handed from address decode to the datapath
  typedef struct packed {
    logic             wrEnable;
    logic             rdEnable;
    logic             rdStatus;
    logic [IDX_W-1:0] cpuSel;
    logic [IDX_W-1:0] grpSel;
  } regStrobe_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NUM_CPUS   = 2,
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam int BANK_BYTES = 8 * NUM_GROUPS;
  localparam int SPAN_BYTES = NUM_CPUS * BANK_BYTES;

  int byteAddr;
  int bankIdx;
  int wordIdx;
  int grpIdx;
  logic inRange;
  logic isEnable;

  always_comb begin
    byteAddr = int'(regAddr);
    inRange  = (byteAddr < SPAN_BYTES);
    bankIdx  = byteAddr / BANK_BYTES;
    wordIdx  = (byteAddr % BANK_BYTES) / 4;
    isEnable = (wordIdx < NUM_GROUPS);
    // reversed word order: highest group at the lowest address in each half
    if (isEnable) grpIdx = NUM_GROUPS - 1 - wordIdx;
    else          grpIdx = 2 * NUM_GROUPS - 1 - wordIdx;

    strb = '0;
    if (regSel && inRange) begin
      strb.cpuSel   = IDX_W'(bankIdx);
      strb.grpSel   = IDX_W'(grpIdx);
      strb.wrEnable = regWrite && isEnable;
      strb.rdEnable = !regWrite && isEnable;
      strb.rdStatus = !regWrite && !isEnable;
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int NUM_CPUS   = 2,
  parameter int NUM_GROUPS = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WORD_BITS*NUM_GROUPS-1:0] irqIn,
  input  regStrobe_t                      strb,
  input  logic [WORD_BITS-1:0]            wdata,
  output logic [WORD_BITS-1:0]            rdata,
  output logic [NUM_CPUS-1:0]             irqOut
);
  localparam int SRC = WORD_BITS * NUM_GROUPS;

  logic [SRC-1:0] syncA;
  logic [SRC-1:0] syncB;
  logic [NUM_CPUS-1:0][NUM_GROUPS-1:0][WORD_BITS-1:0] enWord;
  logic [NUM_CPUS-1:0] pendAny;
  logic [WORD_BITS-1:0] rdNext;

  // two-flop synchroniser shared by both banks
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  // enable words, whole-word writes only
  always_ff @(posedge clk) begin
    if (rst) begin
      enWord <= '0;
    end else if (strb.wrEnable) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (strb.cpuSel == IDX_W'(c) && strb.grpSel == IDX_W'(g))
            enWord[c][g] <= wdata;
        end
      end
    end
  end

  // pending reduction per CPU
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign pendAny[c] = |(enWord[c] & syncB);

    // R10: a fully masked bank never raises its output
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
      (enWord[c] == '0) |=> !irqOut[c]);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      // R9: a write replaces the full word
      a_r9_word_replaced: assert property (@(posedge clk) disable iff (rst)
        (strb.wrEnable && strb.cpuSel == IDX_W'(c) && strb.grpSel == IDX_W'(g))
        |=> enWord[c][g] == $past(wdata));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= '0;
    else     irqOut <= pendAny;
  end

  // read mux
  always_comb begin
    rdNext = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (strb.cpuSel == IDX_W'(c) && strb.grpSel == IDX_W'(g)) begin
          if (strb.rdEnable)      rdNext = enWord[c][g];
          else if (strb.rdStatus) rdNext = syncB[g*WORD_BITS +: WORD_BITS];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdNext;
  end

  // R4 and R8: nothing but an enable-word write changes enable state
  a_r4_enable_held: assert property (@(posedge clk) disable iff (rst)
    !strb.wrEnable |=> $stable(enWord));

  // R2: the bus reads zero in the cycle after no read
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdEnable || strb.rdStatus) |=> rdata == '0);
endmodule

// File: rtl/dual_cpu_irq_ctrl.sv
module dual_cpu_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CPUS   = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WORD_BITS*NUM_GROUPS-1:0] irqIn,
  input  logic                            regSel,
  input  logic                            regWrite,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [WORD_BITS-1:0]            regWdata,
  output logic [WORD_BITS-1:0]            regRdata,
  output logic [NUM_CPUS-1:0]             irqCpu
);
  localparam int SPAN_BYTES = NUM_CPUS * 8 * NUM_GROUPS;

  regStrobe_t strb;

  irqc_decode #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .regSel  (regSel),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irqc_core #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_GROUPS(NUM_GROUPS)
  ) u_core (
    .clk   (clk),
    .rst   (rst),
    .irqIn (irqIn),
    .strb  (strb),
    .wdata (regWdata),
    .rdata (regRdata),
    .irqOut(irqCpu)
  );

  // R8: out-of-range reads return zero
  a_r8_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
    (regSel && !regWrite && (int'(regAddr) >= SPAN_BYTES)) |=> regRdata == '0);
endmodule

// File: tb/sim_dual_cpu_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_cpu_irq_ctrl;
  localparam int G   = 4;
  localparam int NC  = 2;
  localparam int AW  = 8;
  localparam int SRC = 32 * G;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SRC-1:0] irqIn = '0;
  logic regSel = 1'b0;
  logic regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NC-1:0] irqCpu;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  logic seenRead = 1'b0;

  always #2.5 clk = ~clk;

  dual_cpu_irq_ctrl #(.NUM_GROUPS(G), .NUM_CPUS(NC), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .irqIn(irqIn), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqCpu(irqCpu)
  );

  function automatic logic [AW-1:0] enAddr(int c, int g);
    return AW'(c * 8 * G + 4 * (G - 1 - g));
  endfunction

  function automatic logic [AW-1:0] stAddr(int c, int g);
    return AW'(c * 8 * G + 4 * G + 4 * (G - 1 - g));
  endfunction

  // monitor: compare read data against the scoreboard
  always @(posedge clk) seenRead <= regSel && !regWrite && !rst;

  always @(negedge clk) begin
    item_t it;
    if (seenRead) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: got %h expected nothing", regRdata);
      end else begin
        it = sbq.pop_front();
        if (regRdata !== it.exp) begin
          errors++;
          $display("FAIL %s read got %h expected %h", it.tag, regRdata, it.exp);
        end
      end
    end
  end

  task automatic busWrite(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic busRead(logic [AW-1:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    regSel = 1'b0;
  endtask

  task automatic expectIrq(logic [NC-1:0] e, string tag);
    checks++;
    if (irqCpu !== e) begin
      errors++;
      $display("FAIL %s irqCpu got %b expected %b", tag, irqCpu, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired: got running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expectIrq(2'b00, "R1 irq after reset");
    checks++;
    if (regRdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 rdata got %h expected %h", regRdata, 32'h0);
    end
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < G; g++)
        busRead(enAddr(c, g), 32'h0, "R1 enable reset");

    // R2 round trip at reversed addresses
    busWrite(enAddr(0, 0), 32'hA5A5_0001);
    busRead(enAddr(0, 0), 32'hA5A5_0001, "R2 cpu0 grp0");
    busWrite(enAddr(1, 3), 32'hFFFF_0000);
    busRead(enAddr(1, 3), 32'hFFFF_0000, "R2 cpu1 grp3");
    busRead(enAddr(0, 1), 32'h0, "R2 cpu0 grp1 untouched");
    busRead(enAddr(1, 0), 32'h0, "R2 cpu1 grp0 untouched");
    busRead(8'h1C, 32'h0, "R2 cpu0 status grp0 idle");
    expectIrq(2'b00, "R5 no pending");

    // R6 latency from input, R7 steering
    @(negedge clk); irqIn[0] = 1'b1;
    @(negedge clk); expectIrq(2'b00, "R6 edge1");
    @(negedge clk); expectIrq(2'b00, "R6 edge2");
    @(negedge clk); expectIrq(2'b01, "R6 edge3 R7 cpu0 only");
    busRead(stAddr(0, 0), 32'h1, "R3 cpu0 status grp0");
    busRead(stAddr(1, 0), 32'h1, "R7 cpu1 sees same status");

    // R4 status write ignored
    busWrite(stAddr(0, 0), 32'h0);
    busRead(stAddr(0, 0), 32'h1, "R4 status unchanged");
    busRead(enAddr(0, 0), 32'hA5A5_0001, "R4 enable unchanged");
    expectIrq(2'b01, "R4 irq unchanged");

    // R9 whole-word write, R10 masked fall
    busWrite(enAddr(0, 0), 32'h0000_0002);
    expectIrq(2'b01, "R10 before fall");
    @(negedge clk); expectIrq(2'b00, "R10 fall after mask");
    busRead(enAddr(0, 0), 32'h0000_0002, "R9 word replaced");

    // R5 rise one edge after enable write
    busWrite(enAddr(0, 0), 32'h0000_0003);
    expectIrq(2'b00, "R5 before rise");
    @(negedge clk); expectIrq(2'b01, "R5 rise after enable");

    // source 127 steered to cpu1
    @(negedge clk); irqIn[127] = 1'b1;
    @(negedge clk);
    @(negedge clk); expectIrq(2'b01, "R6 src127 edge2");
    @(negedge clk); expectIrq(2'b11, "R7 src127 to cpu1");
    busRead(8'h10, 32'h8000_0000, "R3 offset 0x10 grp3");
    busRead(8'h30, 32'h8000_0000, "R7 cpu1 status grp3");
    busRead(8'h1C, 32'h0000_0001, "R3 offset 0x1C grp0");

    // mask cpu0 only; cpu1 stays up
    busWrite(enAddr(0, 0), 32'h0);
    @(negedge clk); expectIrq(2'b10, "R7 cpu0 masked cpu1 held");

    // input falls
    @(negedge clk); irqIn[127] = 1'b0;
    @(negedge clk);
    @(negedge clk); expectIrq(2'b10, "R10 input fall edge2");
    @(negedge clk); expectIrq(2'b00, "R10 input fall edge3");

    // R8 out of range
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'hFC, 32'hFFFF_FFFF);
    busRead(8'h40, 32'h0, "R8 read 0x40");
    busRead(8'hFC, 32'h0, "R8 read 0xFC");
    busRead(enAddr(0, 1), 32'h0, "R8 cpu0 grp1 intact");
    busRead(enAddr(1, 3), 32'hFFFF_0000, "R8 cpu1 grp3 intact");

    // middle group on cpu1
    busWrite(enAddr(1, 1), 32'h0000_0100);
    @(negedge clk); irqIn[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); expectIrq(2'b10, "R7 src40 to cpu1");
    busRead(stAddr(1, 1), 32'h0000_0100, "R3 cpu1 status grp1");

    repeat (3) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard left %0d expected 0", sbq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule